// File: doc/BRIEF.md
# Macro Result Router with Method Write Port

This block sits at the back end of a small macro sequencer. Each cycle, the execute stage may present an operation. The operation carries a result word, a destination register index and a 3-bit result mode. The router decides four things for it:
- whether the destination register gets the result or the next word popped from the parameter stream;
- whether the result is loaded into the method-address register;
- whether a write request goes out to the downstream engine bus;
- which word that write request carries.

The method-address register is 18 bits wide. It packs a 12-bit target address in bits [11:0] and a 6-bit stride in bits [17:12]. Every accepted write request goes to the current address. After the request, the address field advances by the stride and wraps at 12 bits. The stride field is kept.

An operation completes in the cycle that `op_ready` is high. Completion needs two things: the parameter word, if the mode needs one, must be present, and the write request, if the mode sends one, must be taken. All side effects happen together in that cycle. These are the register write, the parameter pop, the method-address update and the bus handshake. While completion is not possible, the router holds the sequencer and performs none of them.

Top module: `macro_result_router`

## Requirements
- R1: Mode 0 (fetch-discard) writes the next parameter to the destination, sends nothing and leaves the method address unchanged.
- R2: Mode 1 (move) writes the result to the destination. Mode 2 (move-and-load) also loads result bits [17:0] into the method-address register. Neither mode sends.
- R3: Mode 3 (fetch-and-send) writes the next parameter to the destination and sends the result to the current method address.
- R4: Mode 4 (move-and-send) writes the result to the destination and sends the result to the current method address.
- R5: Mode 5 (fetch-and-load) writes the next parameter to the destination, loads the result as the method address and sends nothing.
- R6: Mode 6 writes the result to the destination, loads it as the method address, and sends the next parameter to the newly loaded address.
- R7: Mode 7 writes the result to the destination, loads it as the method address, and sends result bits [17:12], zero-extended, to the newly loaded address.
- R8: After each accepted send, the method-address bits [11:0] become (address + stride) mod 4096, where the stride is bits [17:12]. The stride is preserved. Without a send or a load, the register holds its value.
- R9: If the mode needs a parameter and `prm_valid` is low, `op_ready`, `prm_pop`, `rf_we` and `snd_valid` all stay low.
- R10: If the mode sends and `snd_ready` is low, the operation does not complete. `snd_valid` is high, and there is no pop, no register write and no method-address change.
- R11: A destination index of 0 never raises `rf_we`.
- R12: After reset the method address is 0, and with `op_valid` low no output strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present from execute stage |
| op_mode | input | 3 | Result mode, encoding 0..7 as in R1..R7 |
| op_result | input | 32 | Execute result word |
| op_dst | input | 3 | Destination register index |
| op_ready | output | 1 | Operation completes this cycle |
| prm_valid | input | 1 | Parameter stream has a word |
| prm_data | input | 32 | Head word of the parameter stream |
| prm_pop | output | 1 | Consume the head parameter word |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 3 | Register-file write index |
| rf_data | output | 32 | Register-file write data |
| snd_valid | output | 1 | Write request to the engine bus |
| snd_ready | input | 1 | Engine bus takes the request |
| snd_addr | output | 12 | Target method address |
| snd_data | output | 32 | Write data |

## Verification
The assertions check three things on every cycle. A pop never occurs without a parameter present. A completed send always had `snd_ready`. Writes never reach register 0. The method-address register also stays put when no operation completes, and it advances by its own stride after a plain send. The bench covers what the assertions cannot: the data path for each of the eight modes, and the choice between the current address and a newly loaded address. Its directed scenarios also cover wrap at 4096, a send of the stride field, and stalls from an empty parameter stream and from a busy bus.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

   typedef enum logic [2:0] {
      MODE_FETCH_DISCARD  = 3'd0,
      MODE_MOVE           = 3'd1,
      MODE_MOVE_LOAD      = 3'd2,
      MODE_FETCH_SEND     = 3'd3,
      MODE_MOVE_SEND      = 3'd4,
      MODE_FETCH_LOAD     = 3'd5,
      MODE_MOVE_LOAD_PSND = 3'd6,
      MODE_MOVE_LOAD_FSND = 3'd7
   } mrr_mode_e;

   typedef enum logic {
      WB_FROM_RESULT = 1'b0,
      WB_FROM_PARAM  = 1'b1
   } mrr_wb_e;

   typedef enum logic [1:0] {
      SND_FROM_RESULT = 2'd0,
      SND_FROM_PARAM  = 2'd1,
      SND_FROM_FIELD  = 2'd2
   } mrr_snd_e;

   typedef struct packed {
      logic     fetch;
      mrr_wb_e  wb_sel;
      logic     load;
      logic     send;
      mrr_snd_e snd_sel;
   } mrr_ctrl_t;

endpackage

// File: rtl/mrr_decode.sv
module mrr_decode
   import mrr_pkg::*;
(
   input  logic [2:0] mode,
   output mrr_ctrl_t  ctrl
);

   always_comb begin
      ctrl = '{fetch: 1'b0, wb_sel: WB_FROM_RESULT, load: 1'b0,
               send: 1'b0, snd_sel: SND_FROM_RESULT};
      unique case (mrr_mode_e'(mode))
         MODE_FETCH_DISCARD: begin
            ctrl.fetch  = 1'b1;
            ctrl.wb_sel = WB_FROM_PARAM;
         end
         MODE_MOVE: ;
         MODE_MOVE_LOAD: ctrl.load = 1'b1;
         MODE_FETCH_SEND: begin
            ctrl.fetch  = 1'b1;
            ctrl.wb_sel = WB_FROM_PARAM;
            ctrl.send   = 1'b1;
         end
         MODE_MOVE_SEND: ctrl.send = 1'b1;
         MODE_FETCH_LOAD: begin
            ctrl.fetch  = 1'b1;
            ctrl.wb_sel = WB_FROM_PARAM;
            ctrl.load   = 1'b1;
         end
         MODE_MOVE_LOAD_PSND: begin
            ctrl.load    = 1'b1;
            ctrl.fetch   = 1'b1;
            ctrl.send    = 1'b1;
            ctrl.snd_sel = SND_FROM_PARAM;
         end
         MODE_MOVE_LOAD_FSND: begin
            ctrl.load    = 1'b1;
            ctrl.send    = 1'b1;
            ctrl.snd_sel = SND_FROM_FIELD;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mrr_join.sv
module mrr_join (
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  logic need_fetch,
   input  logic need_send,
   input  logic prm_valid,
   input  logic snd_ready,
   output logic commit,
   output logic prm_pop,
   output logic snd_valid
);

   logic fetch_ok;
   logic send_ok;

   assign fetch_ok  = !need_fetch || prm_valid;
   assign send_ok   = !need_send  || snd_ready;
   assign commit    = op_valid && fetch_ok && send_ok;
   assign prm_pop   = commit && need_fetch;
   assign snd_valid = op_valid && need_send && fetch_ok;

   // R9
   pop_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prm_pop |-> prm_valid);

   // R10
   send_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !snd_ready) |-> !commit);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!commit && !prm_pop && !snd_valid));

endmodule

// File: rtl/mrr_method_reg.sv
module mrr_method_reg #(
   parameter int MADDR_W = 12,
   parameter int INC_W   = 6,
   localparam int MREG_W = MADDR_W + INC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              load,
   input  logic [MREG_W-1:0] load_val,
   input  logic              advance,
   output logic [MREG_W-1:0] eff
);

   logic [MREG_W-1:0]  cur_q;
   logic [MADDR_W-1:0] eff_addr;
   logic [INC_W-1:0]   eff_inc;
   logic [MADDR_W-1:0] next_addr;

   assign eff       = load ? load_val : cur_q;
   assign eff_addr  = eff[MADDR_W-1:0];
   assign eff_inc   = eff[MREG_W-1:MADDR_W];
   assign next_addr = eff_addr + MADDR_W'(eff_inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (commit) begin
         if (advance)   cur_q <= {eff_inc, next_addr};
         else if (load) cur_q <= load_val;
      end
   end

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cur_q));

   // R8
   stride_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && advance && !load) |=>
         (cur_q[MADDR_W-1:0] == MADDR_W'($past(cur_q[MADDR_W-1:0]) +
                                          MADDR_W'($past(cur_q[MREG_W-1:MADDR_W])))
          && $stable(cur_q[MREG_W-1:MADDR_W])));

endmodule

// File: rtl/macro_result_router.sv
module macro_result_router
   import mrr_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int REG_AW        = 3,
   parameter int MADDR_W       = 12,
   parameter int INC_W         = 6,
   parameter bit ZERO_REG_SINK = 1'b1,
   localparam int MREG_W       = MADDR_W + INC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_mode,
   input  logic [DATA_W-1:0] op_result,
   input  logic [REG_AW-1:0] op_dst,
   output logic              op_ready,
   input  logic              prm_valid,
   input  logic [DATA_W-1:0] prm_data,
   output logic              prm_pop,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              snd_valid,
   input  logic              snd_ready,
   output logic [MADDR_W-1:0] snd_addr,
   output logic [DATA_W-1:0] snd_data
);

   if (DATA_W < MREG_W) begin : g_bad_data_w
      $error("DATA_W must hold the whole method-address register");
   end
   if (MADDR_W < 1 || INC_W < 1 || REG_AW < 1) begin : g_bad_field_w
      $error("field widths must be positive");
   end

   mrr_ctrl_t         ctrl;
   logic              commit;
   logic [MREG_W-1:0] eff;
   logic [DATA_W-1:0] field_word;

   mrr_decode i_decode (
      .mode (op_mode),
      .ctrl (ctrl)
   );

   mrr_join i_join (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .need_fetch (ctrl.fetch),
      .need_send  (ctrl.send),
      .prm_valid  (prm_valid),
      .snd_ready  (snd_ready),
      .commit     (commit),
      .prm_pop    (prm_pop),
      .snd_valid  (snd_valid)
   );

   mrr_method_reg #(
      .MADDR_W (MADDR_W),
      .INC_W   (INC_W)
   ) i_mreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .load     (ctrl.load),
      .load_val (op_result[MREG_W-1:0]),
      .advance  (ctrl.send),
      .eff      (eff)
   );

   assign op_ready   = commit;
   assign field_word = DATA_W'(op_result[MREG_W-1:MADDR_W]);

   assign rf_addr = op_dst;
   assign rf_data = (ctrl.wb_sel == WB_FROM_PARAM) ? prm_data : op_result;

   if (ZERO_REG_SINK) begin : g_zero_sink
      assign rf_we = commit && (op_dst != '0);
   end else begin : g_zero_plain
      assign rf_we = commit;
   end

   assign snd_addr = eff[MADDR_W-1:0];

   always_comb begin
      unique case (ctrl.snd_sel)
         SND_FROM_PARAM: snd_data = prm_data;
         SND_FROM_FIELD: snd_data = field_word;
         default:        snd_data = op_result;
      endcase
   end

   // R11
   zero_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (!ZERO_REG_SINK || rf_addr != '0));

   // R9
   write_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> op_ready);

   // R10
   stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && !snd_ready) |-> (!prm_pop && !rf_we));

endmodule

// File: tb/test_macro_result_router.sv
module test_macro_result_router;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_mode = '0;
   logic [31:0] op_result = '0;
   logic [2:0]  op_dst = '0;
   logic        op_ready;
   logic        prm_valid;
   logic [31:0] prm_data;
   logic        prm_pop;
   logic        rf_we;
   logic [2:0]  rf_addr;
   logic [31:0] rf_data;
   logic        snd_valid;
   logic        snd_ready = 1'b0;
   logic [11:0] snd_addr;
   logic [31:0] snd_data;

   logic        prm_gate = 1'b0;
   logic [31:0] pq[$];
   logic [17:0] m_reg;
   int          n_vec = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign prm_valid = prm_gate && (pq.size() > 0);
   assign prm_data  = (pq.size() > 0) ? pq[0] : 32'h0;

   macro_result_router i_macro_result_router (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
      .op_result(op_result), .op_dst(op_dst), .op_ready(op_ready),
      .prm_valid(prm_valid), .prm_data(prm_data), .prm_pop(prm_pop),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
      .snd_valid(snd_valid), .snd_ready(snd_ready),
      .snd_addr(snd_addr), .snd_data(snd_data)
   );

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   function automatic string mode_tag(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1, 3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         3'd5: return "R5";
         3'd6: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare, then advance model at posedge
   task automatic step(input logic v, input logic [2:0] m, input logic [31:0] res,
                       input logic [2:0] dst, input logic pv, input logic sr);
      logic fetch, load, send, wbp, avail, rdy, wexp;
      logic [17:0] eff;
      logic [31:0] sdat;
      string stall_tag;
      op_valid = v; op_mode = m; op_result = res; op_dst = dst;
      prm_gate = pv; snd_ready = sr;
      #1;
      fetch = (m == 0) || (m == 3) || (m == 5) || (m == 6);
      load  = (m == 2) || (m == 5) || (m == 6) || (m == 7);
      send  = (m == 3) || (m == 4) || (m == 6) || (m == 7);
      wbp   = (m == 0) || (m == 3) || (m == 5);
      avail = pv && (pq.size() > 0);
      eff   = load ? res[17:0] : m_reg;
      rdy   = v && (!fetch || avail) && (!send || sr);
      wexp  = rdy && (dst != 0);
      stall_tag = !v ? "R12" : (fetch && !avail) ? "R9" : (send && !sr) ? "R10" : mode_tag(m);
      chk(stall_tag, "op_ready", 32'(op_ready), 32'(rdy));
      chk(stall_tag, "prm_pop", 32'(prm_pop), 32'(rdy && fetch));
      chk((dst == 0) ? "R11" : stall_tag, "rf_we", 32'(rf_we), 32'(wexp));
      chk(stall_tag, "snd_valid", 32'(snd_valid), 32'(v && send && (!fetch || avail)));
      if (wexp) begin
         chk(mode_tag(m), "rf_addr", 32'(rf_addr), 32'(dst));
         chk(mode_tag(m), "rf_data", rf_data, wbp ? pq[0] : res);
      end
      if (v && send && (!fetch || avail)) begin
         if (m == 6) sdat = pq[0];
         else if (m == 7) sdat = {26'd0, res[17:12]};
         else sdat = res;
         chk(load ? mode_tag(m) : "R8", "snd_addr", 32'(snd_addr), 32'(eff[11:0]));
         chk(mode_tag(m), "snd_data", snd_data, sdat);
      end
      @(posedge clk);
      if (rdy) begin
         if (send) m_reg = {eff[17:12], eff[11:0] + 12'(eff[17:12])};
         else if (load) m_reg = eff;
         if (fetch) void'(pq.pop_front());
      end
      @(negedge clk);
   endtask

   initial begin
      m_reg = '0;
      repeat (3) @(negedge clk);
      // R12: idle outputs in reset and just after
      chk("R12", "op_ready in reset", 32'(op_ready), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, 3'd4, 32'h1234, 3'd1, 1'b1, 1'b1);
      // R12: first send after reset goes to address 0; R4
      step(1'b1, 3'd4, 32'hAAAA_5555, 3'd2, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) pq.push_back(32'hC0DE_0000 + 32'(i));
      // R1 fetch-discard
      step(1'b1, 3'd0, 32'hDEAD_BEEF, 3'd3, 1'b1, 1'b0);
      // R2 move and move-and-load: address 0xFFF, stride 2
      step(1'b1, 3'd1, 32'h0000_0077, 3'd4, 1'b0, 1'b0);
      step(1'b1, 3'd2, 32'h0000_2FFF, 3'd5, 1'b0, 1'b0);
      // R8 wrap: sends to 0xFFF then 0x001
      step(1'b1, 3'd4, 32'h0000_0011, 3'd6, 1'b0, 1'b1);
      step(1'b1, 3'd3, 32'h0000_0022, 3'd7, 1'b1, 1'b1);
      // R9 empty parameter stream stalls
      step(1'b1, 3'd5, 32'h0001_5100, 3'd1, 1'b0, 1'b1);
      // R10 bus busy stalls
      step(1'b1, 3'd6, 32'h0000_7040, 3'd2, 1'b1, 1'b0);
      // R5, R6, R7
      step(1'b1, 3'd5, 32'h0001_5100, 3'd1, 1'b1, 1'b1);
      step(1'b1, 3'd6, 32'h0000_7040, 3'd2, 1'b1, 1'b1);
      step(1'b1, 3'd7, 32'h0003_F800, 3'd3, 1'b0, 1'b1);
      step(1'b1, 3'd4, 32'h0000_0099, 3'd3, 1'b0, 1'b1);
      // R11 destination zero
      step(1'b1, 3'd1, 32'h0000_0055, 3'd0, 1'b0, 1'b0);
      step(1'b1, 3'd0, 32'h0000_0055, 3'd0, 1'b1, 1'b0);
      // mixed traffic across all modes
      for (int i = 0; i < 3000; i++) begin
         if (pq.size() < 4) pq.push_back($urandom());
         step(($urandom() % 5) != 0, 3'($urandom()), $urandom(), 3'($urandom()),
              ($urandom() % 4) != 0, ($urandom() % 3) != 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule